// File: doc/BRIEF.md
# Dual-Mapped Peripheral Register Space

This block is the peripheral register space of a small 8-bit processor core. The core issues one request per cycle, qualified by a strobe. The request can be a port-style I/O read or write on a 6-bit I/O address, or a data-space load or store on an 8-bit address. It can also be an atomic set or clear of one bit, or a test of one bit. Every register in the I/O range appears twice. It sits at its I/O address for port-style access and at that address plus 0x20 for data-space access. Above the aliased range there is an extended window that only loads and stores can reach.

The space holds three 8-bit scratch registers and one status register. The status register carries four event flags. An external event input sets a flag. Software clears a flag by writing a one to it, and writing a zero leaves it unchanged. A single-bit set aimed at a status flag clears only that one flag, so the other pending flags survive it. Two more scratch registers sit in the extended window.

A small response machine turns each strobe into a result in the next cycle. It has three states. RESP_IDLE means no result is pending. RESP_READ presents read data. RESP_TEST presents a bit-test result. Every cycle the machine takes the state chosen by the current request. An accepted read or load goes to RESP_READ, an accepted bit test goes to RESP_TEST, and anything else goes to RESP_IDLE. Back-to-back requests therefore move it directly between any two states.

Top module: `periph_regspace`

## Requirements
- R1: Port-style access (req_op 0 = read, 1 = write) reaches I/O addresses 0x00 to 0x3F only. A port-style write with req_addr at or above 0x40 changes nothing, and a port-style read there returns 0x00.
- R2: A data-space load (req_op 2) or store (req_op 3) at address A in 0x20 to 0x5F reaches the same register as I/O address A minus 0x20.
- R3: Data addresses 0x60 to 0xFF form an extended window reachable only by loads and stores. It holds two R/W scratch registers at data addresses 0x80 and 0x81, both resetting to 0x00. No port-style access reaches them.
- R4: A bit set (req_op 4) or bit clear (req_op 5) on a scratch register sets or clears bit req_bit and leaves the other seven bits as they were.
- R5: Bit set, bit clear and bit test (req_op 6) are accepted only for req_addr 0x00 to 0x1F. Above that range they change no register and produce no test response.
- R6: The status register sits at I/O address 0x1A and has flags in bits 3:0. Writing a one to a flag clears it, and writing a zero leaves it unchanged. Bits 7:4 always read as zero.
- R7: A bit set on the status register clears only the flag named by req_bit. A bit clear on the status register has no effect.
- R8: A one on flag_evt[k] sets flag k at the next clock edge. If software clears that flag in the same cycle, the set takes priority.
- R9: The scratch registers sit at I/O addresses 0x1C, 0x1D and 0x1E. All eight bits of each are readable and writable, and every bit resets to 0.
- R10: A write to an unmapped address changes nothing, and a read of one returns 0x00. req_op 7 is a no-operation.
- R11: Results appear in the cycle after the strobe. An accepted read or load raises rd_valid with the data on rd_data. An accepted bit test raises test_valid, with test_result equal to the selected bit. In other cycles both strobes are low and rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 I/O read, 1 I/O write, 2 load, 3 store, 4 bit set, 5 bit clear, 6 bit test, 7 no-op) |
| req_addr | input | 8 | I/O address for port-style and bit operations, data address for loads and stores |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data |
| flag_evt | input | 4 | Event inputs that set the status flags |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 8 | Read data |
| test_valid | output | 1 | Bit-test result valid |
| test_result | output | 1 | Value of the tested bit |

## Verification
Two things can land on the same status flag in one cycle: an event on flag_evt, and a software clear of that flag. The clear can come from a data-space store with a one in that bit, or from a single-bit set on the status register. The bench raises the event in the very cycle it issues each kind of clear. It then reads the status register through the port-style alias. The targeted flag must still be set, and the flags the clear did not target must be unchanged.

// File: rtl/regspace_pkg.sv
`timescale 1ns/1ps
package regspace_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [2:0] {
        OP_IO_RD = 3'd0,
        OP_IO_WR = 3'd1,
        OP_LD    = 3'd2,
        OP_ST    = 3'd3,
        OP_BSET  = 3'd4,
        OP_BCLR  = 3'd5,
        OP_BTST  = 3'd6,
        OP_NOP   = 3'd7
    } req_op_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_GP   = 2'd1,
        TGT_FLAG = 2'd2,
        TGT_EXT  = 2'd3
    } tgt_t;

    typedef enum logic [1:0] {
        RESP_IDLE = 2'd0,
        RESP_READ = 2'd1,
        RESP_TEST = 2'd2
    } resp_state_t;

endpackage

// File: rtl/regspace_decode.sv
`timescale 1ns/1ps
module regspace_decode
    import regspace_pkg::*;
#(
    parameter int IO_AW         = 6,
    parameter int NUM_GP        = 3,
    parameter int NUM_EXT       = 2,
    parameter int GP_IO_BASE    = 'h1C,
    parameter int FLAG_IO_ADDR  = 'h1A,
    parameter int EXT_DATA_BASE = 'h80
) (
    input  logic [2:0]          op,
    input  logic [IO_AW+1:0]    addr,
    output tgt_t                tgt,
    output logic [IDX_W-1:0]    idx,
    output logic                is_rd,
    output logic                is_wr,
    output logic                is_bset,
    output logic                is_bclr,
    output logic                is_tst
);

    localparam int DATA_AW = IO_AW + 2;
    localparam logic [DATA_AW-1:0] IO_SPAN_A   = DATA_AW'(1 << IO_AW);
    localparam logic [DATA_AW-1:0] BITWIN_A    = DATA_AW'(1 << (IO_AW - 1));
    localparam logic [DATA_AW-1:0] EXT_START_A = IO_SPAN_A + BITWIN_A;
    localparam logic [DATA_AW-1:0] EXT_BASE_A  = DATA_AW'(EXT_DATA_BASE);

    req_op_t            op_e;
    logic               io_hit;
    logic               ext_hit;
    logic [IO_AW-1:0]   io_addr;
    logic [DATA_AW-1:0] ext_off;

    assign op_e    = req_op_t'(op);
    assign ext_off = addr - EXT_BASE_A;

    // Which address space the request lands in
    always_comb begin
        io_hit  = 1'b0;
        ext_hit = 1'b0;
        io_addr = addr[IO_AW-1:0];
        is_rd   = 1'b0;
        is_wr   = 1'b0;
        is_bset = 1'b0;
        is_bclr = 1'b0;
        is_tst  = 1'b0;
        unique case (op_e)
            OP_IO_RD: begin
                is_rd  = 1'b1;
                io_hit = (addr < IO_SPAN_A);
            end
            OP_IO_WR: begin
                is_wr  = 1'b1;
                io_hit = (addr < IO_SPAN_A);
            end
            OP_LD, OP_ST: begin
                is_rd = (op_e == OP_LD);
                is_wr = (op_e == OP_ST);
                if (addr >= BITWIN_A && addr < EXT_START_A) begin
                    io_hit  = 1'b1;
                    io_addr = IO_AW'(addr - BITWIN_A);
                end else if (addr >= EXT_START_A) begin
                    ext_hit = 1'b1;
                end
            end
            OP_BSET: begin
                is_bset = (addr < BITWIN_A);
                io_hit  = is_bset;
            end
            OP_BCLR: begin
                is_bclr = (addr < BITWIN_A);
                io_hit  = is_bclr;
            end
            OP_BTST: begin
                is_tst = (addr < BITWIN_A);
                io_hit = is_tst;
            end
            OP_NOP: ;
        endcase
    end

    // Which register inside that space
    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (io_hit) begin
            if (io_addr == IO_AW'(FLAG_IO_ADDR)) begin
                tgt = TGT_FLAG;
            end
            for (int i = 0; i < NUM_GP; i++) begin
                if (io_addr == IO_AW'(GP_IO_BASE + i)) begin
                    tgt = TGT_GP;
                    idx = IDX_W'(i);
                end
            end
        end
        if (ext_hit) begin
            for (int j = 0; j < NUM_EXT; j++) begin
                if (ext_off == DATA_AW'(j)) begin
                    tgt = TGT_EXT;
                    idx = IDX_W'(j);
                end
            end
        end
    end

endmodule

// File: rtl/scratch_bank.sv
`timescale 1ns/1ps
module scratch_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int BIT_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              sel,
    input  logic                             wr,
    input  logic                             bset,
    input  logic                             bclr,
    input  logic [BIT_W-1:0]                 bit_idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (sel[r]) begin
                    if (wr) begin
                        q[r] <= wdata;
                    end else if (bset) begin
                        q[r][bit_idx] <= 1'b1;
                    end else if (bclr) begin
                        q[r][bit_idx] <= 1'b0;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R4: a bit operation moves at most one bit
        a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[g] && !wr && (bset || bclr)) |=> ($countones(q[g] ^ $past(q[g])) <= 1));
        // R10: an unselected register keeps its value
        a_r10_hold_unsel: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[g] |=> $stable(q[g]));
    end

endmodule

// File: rtl/flag_reg.sv
`timescale 1ns/1ps
module flag_reg #(
    parameter int NUM_FLAGS = 4,
    parameter int BIT_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FLAGS-1:0]  evt,
    input  logic                  sel,
    input  logic                  wr,
    input  logic                  bset,
    input  logic [NUM_FLAGS-1:0]  wmask,
    input  logic [BIT_W-1:0]      bit_idx,
    output logic [NUM_FLAGS-1:0]  flags
);

    logic [NUM_FLAGS-1:0] clr;

    always_comb begin
        for (int k = 0; k < NUM_FLAGS; k++) begin
            clr[k] = sel && ((wr && wmask[k]) || (bset && bit_idx == BIT_W'(k)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | evt;
        end
    end

    // R8: an event always lands, whatever else happens that cycle
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));
    // R6: no flag rises without its event
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(evt)) == '0));
    // R7: a bit set clears at most one flag
    a_r7_one_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && bset && !wr) |=> ($countones($past(flags) & ~flags) <= 1));

endmodule

// File: rtl/periph_regspace.sv
`timescale 1ns/1ps
module periph_regspace
    import regspace_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int IO_AW         = 6,
    parameter int NUM_GP        = 3,
    parameter int NUM_EXT       = 2,
    parameter int NUM_FLAGS     = 4,
    parameter int GP_IO_BASE    = 'h1C,
    parameter int FLAG_IO_ADDR  = 'h1A,
    parameter int EXT_DATA_BASE = 'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [IO_AW+1:0]      req_addr,
    input  logic [$clog2(DATA_W)-1:0] req_bit,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [NUM_FLAGS-1:0]  flag_evt,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  test_valid,
    output logic                  test_result
);

    localparam int DATA_AW = IO_AW + 2;
    localparam int BIT_W   = $clog2(DATA_W);
    localparam logic [DATA_AW-1:0] IO_SPAN_A = DATA_AW'(1 << IO_AW);
    localparam logic [DATA_AW-1:0] BITWIN_A  = DATA_AW'(1 << (IO_AW - 1));

    tgt_t                           tgt;
    logic [IDX_W-1:0]               idx;
    logic                           is_rd, is_wr, is_bset, is_bclr, is_tst;
    logic [NUM_GP-1:0]              gp_sel;
    logic [NUM_EXT-1:0]             ext_sel;
    logic                           flag_sel;
    logic [NUM_GP-1:0][DATA_W-1:0]  gp_q;
    logic [NUM_EXT-1:0][DATA_W-1:0] ext_q;
    logic [NUM_FLAGS-1:0]           flags;
    logic [DATA_W-1:0]              sel_val;
    resp_state_t                    state_q, state_d;
    logic [DATA_W-1:0]              data_q;
    logic                           bit_q;
    req_op_t                        op_e;

    assign op_e = req_op_t'(req_op);

    regspace_decode #(
        .IO_AW         (IO_AW),
        .NUM_GP        (NUM_GP),
        .NUM_EXT       (NUM_EXT),
        .GP_IO_BASE    (GP_IO_BASE),
        .FLAG_IO_ADDR  (FLAG_IO_ADDR),
        .EXT_DATA_BASE (EXT_DATA_BASE)
    ) u_decode (
        .op      (req_op),
        .addr    (req_addr),
        .tgt     (tgt),
        .idx     (idx),
        .is_rd   (is_rd),
        .is_wr   (is_wr),
        .is_bset (is_bset),
        .is_bclr (is_bclr),
        .is_tst  (is_tst)
    );

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_sel
        assign gp_sel[g] = req_valid && (tgt == TGT_GP) && (idx == IDX_W'(g));
    end
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext_sel
        assign ext_sel[e] = req_valid && (tgt == TGT_EXT) && (idx == IDX_W'(e));
    end
    assign flag_sel = req_valid && (tgt == TGT_FLAG);

    scratch_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_GP),
        .BIT_W    (BIT_W)
    ) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (gp_sel),
        .wr      (is_wr),
        .bset    (is_bset),
        .bclr    (is_bclr),
        .bit_idx (req_bit),
        .wdata   (req_wdata),
        .q       (gp_q)
    );

    scratch_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_EXT),
        .BIT_W    (BIT_W)
    ) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ext_sel),
        .wr      (is_wr),
        .bset    (1'b0),
        .bclr    (1'b0),
        .bit_idx (req_bit),
        .wdata   (req_wdata),
        .q       (ext_q)
    );

    flag_reg #(
        .NUM_FLAGS (NUM_FLAGS),
        .BIT_W     (BIT_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (flag_evt),
        .sel     (flag_sel),
        .wr      (is_wr),
        .bset    (is_bset),
        .wmask   (req_wdata[NUM_FLAGS-1:0]),
        .bit_idx (req_bit),
        .flags   (flags)
    );

    // Read source selection
    always_comb begin
        sel_val = '0;
        unique case (tgt)
            TGT_GP: begin
                for (int i = 0; i < NUM_GP; i++) begin
                    if (idx == IDX_W'(i)) sel_val = gp_q[i];
                end
            end
            TGT_EXT: begin
                for (int j = 0; j < NUM_EXT; j++) begin
                    if (idx == IDX_W'(j)) sel_val = ext_q[j];
                end
            end
            TGT_FLAG: sel_val = DATA_W'(flags);
            TGT_NONE: sel_val = '0;
        endcase
    end

    // Response machine: next state
    always_comb begin
        state_d = RESP_IDLE;
        if (req_valid && is_rd) begin
            state_d = RESP_READ;
        end else if (req_valid && is_tst) begin
            state_d = RESP_TEST;
        end
    end

    // Response machine: state register and captured payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESP_IDLE;
            data_q  <= '0;
            bit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == RESP_READ) ? sel_val : '0;
            bit_q   <= (state_d == RESP_TEST) && sel_val[req_bit];
        end
    end

    // Response machine: outputs
    always_comb begin
        rd_valid    = 1'b0;
        rd_data     = '0;
        test_valid  = 1'b0;
        test_result = 1'b0;
        unique case (state_q)
            RESP_IDLE: ;
            RESP_READ: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            RESP_TEST: begin
                test_valid  = 1'b1;
                test_result = bit_q;
            end
            default: ;
        endcase
    end

    // R11: a read strobe yields read data next cycle
    a_r11_read_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op_e == OP_IO_RD || op_e == OP_LD)) |=> (rd_valid && !test_valid));
    // R11: an in-range bit test yields a result next cycle
    a_r11_test_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_e == OP_BTST && req_addr < BITWIN_A) |=> (test_valid && !rd_valid));
    // R5: a bit test above the low window is dropped
    a_r5_test_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_e == OP_BTST && req_addr >= BITWIN_A) |=> !test_valid);
    // R1: port-style read beyond the I/O span returns zero
    a_r1_io_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_e == OP_IO_RD && req_addr >= IO_SPAN_A) |=> (rd_valid && rd_data == '0));
    // R3: port-style writes never touch the extended window
    a_r3_io_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_e == OP_IO_WR) |=> $stable(ext_q));
    // R6: reserved status bits stay zero on every read
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_e == OP_IO_RD && req_addr == DATA_AW'(FLAG_IO_ADDR))
            |=> (rd_data[DATA_W-1:NUM_FLAGS] == '0));

endmodule

// File: tb/periph_regspace_test.sv
`timescale 1ns/1ps
module periph_regspace_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] req_wdata = '0;
    logic [3:0] flag_evt = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       test_valid;
    logic       test_result;

    periph_regspace uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_bit     (req_bit),
        .req_wdata   (req_wdata),
        .flag_evt    (flag_evt),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .test_valid  (test_valid),
        .test_result (test_result)
    );

    always #2.5 clk = ~clk;

    typedef enum {K_NONE, K_READ, K_TEST} kind_t;
    typedef struct {
        kind_t      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one request per call, expectation pushed to the scoreboard
    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [2:0] b,
                         input logic [7:0] w, input logic [3:0] e,
                         input kind_t k, input logic [7:0] x, input string tag);
        item_t it;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_bit   = b;
        req_wdata = w;
        flag_evt  = e;
        it.kind = k;
        it.exp  = x;
        it.tag  = tag;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        flag_evt  = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] x, input string tag);
        issue(3'd0, a, 3'd0, 8'h00, 4'h0, K_READ, x, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] w, input string tag);
        issue(3'd1, a, 3'd0, w, 4'h0, K_NONE, 8'h00, tag);
    endtask
    task automatic ld(input logic [7:0] a, input logic [7:0] x, input string tag);
        issue(3'd2, a, 3'd0, 8'h00, 4'h0, K_READ, x, tag);
    endtask
    task automatic st(input logic [7:0] a, input logic [7:0] w, input string tag);
        issue(3'd3, a, 3'd0, w, 4'h0, K_NONE, 8'h00, tag);
    endtask
    task automatic bs(input logic [7:0] a, input logic [2:0] b, input string tag);
        issue(3'd4, a, b, 8'h00, 4'h0, K_NONE, 8'h00, tag);
    endtask
    task automatic bc(input logic [7:0] a, input logic [2:0] b, input string tag);
        issue(3'd5, a, b, 8'h00, 4'h0, K_NONE, 8'h00, tag);
    endtask
    task automatic bt(input logic [7:0] a, input logic [2:0] b, input logic x, input string tag);
        issue(3'd6, a, b, 8'h00, 4'h0, K_TEST, {7'b0, x}, tag);
    endtask

    // Monitor: compares each result against the oldest expectation
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                unique case (it.kind)
                    K_READ: check(rd_valid && !test_valid && rd_data == it.exp,
                                  it.tag, "read data", rd_data, it.exp);
                    K_TEST: check(test_valid && !rd_valid && test_result == it.exp[0],
                                  it.tag, "bit test", {6'b0, test_valid, test_result}, {6'b0, 1'b1, it.exp[0]});
                    K_NONE: check(!rd_valid && !test_valid,
                                  it.tag, "no response", {6'b0, rd_valid, test_valid}, 8'h00);
                endcase
            end else if (rd_valid || test_valid) begin
                check(1'b0, "R11", "unexpected response", {6'b0, rd_valid, test_valid}, 8'h00);
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual hung expected complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: quiet outputs in reset
        check(!rd_valid && !test_valid && rd_data == 8'h00, "R11", "reset outputs",
              {rd_valid, test_valid, 6'b0} | rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R6 / R3: reset values
        rd(8'h1C, 8'h00, "R9");
        rd(8'h1D, 8'h00, "R9");
        rd(8'h1E, 8'h00, "R9");
        rd(8'h1A, 8'h00, "R6");
        ld(8'h80, 8'h00, "R3");

        // R9 / R2: full-width access and the data-space alias
        wr(8'h1C, 8'hA5, "R9");
        rd(8'h1C, 8'hA5, "R9");
        ld(8'h3C, 8'hA5, "R2");
        st(8'h3D, 8'h5A, "R2");
        rd(8'h1D, 8'h5A, "R2");
        wr(8'h1E, 8'hFF, "R9");
        rd(8'h1E, 8'hFF, "R9");

        // R4: single-bit set and clear
        bc(8'h1C, 3'd0, "R4");
        bs(8'h1C, 3'd6, "R4");
        rd(8'h1C, 8'hE4, "R4");
        bt(8'h1C, 3'd7, 1'b1, "R4");
        bt(8'h1C, 3'd3, 1'b0, "R11");
        bt(8'h1C, 3'd2, 1'b1, "R11");

        // R5: bit operations above the low window are dropped
        bs(8'h3C, 3'd1, "R5");
        rd(8'h1C, 8'hE4, "R5");
        issue(3'd6, 8'h3C, 3'd7, 8'h00, 4'h0, K_NONE, 8'h00, "R5");
        bc(8'h3E, 3'd7, "R5");
        rd(8'h1E, 8'hFF, "R5");

        // R3: extended window through loads and stores only
        st(8'h80, 8'h3C, "R3");
        st(8'h81, 8'hC3, "R3");
        ld(8'h80, 8'h3C, "R3");
        ld(8'h81, 8'hC3, "R3");
        wr(8'h60, 8'h77, "R3");
        wr(8'h80, 8'h77, "R3");
        ld(8'h80, 8'h3C, "R3");

        // R1: port-style range limit
        rd(8'h60, 8'h00, "R1");
        wr(8'h5C, 8'h11, "R1");
        rd(8'h1C, 8'hE4, "R1");

        // R6 / R7 / R8: status flags
        issue(3'd7, 8'h00, 3'd0, 8'h00, 4'hF, K_NONE, 8'h00, "R8");
        rd(8'h1A, 8'h0F, "R8");
        wr(8'h1A, 8'h05, "R6");
        rd(8'h1A, 8'h0A, "R6");
        wr(8'h1A, 8'hF0, "R6");
        rd(8'h1A, 8'h0A, "R6");
        bs(8'h1A, 3'd3, "R7");
        rd(8'h1A, 8'h02, "R7");
        bc(8'h1A, 3'd1, "R7");
        rd(8'h1A, 8'h02, "R7");
        bt(8'h1A, 3'd1, 1'b1, "R7");
        bt(8'h1A, 3'd0, 1'b0, "R7");

        // R8: event and clear in the same cycle
        issue(3'd3, 8'h3A, 3'd0, 8'h08, 4'h8, K_NONE, 8'h00, "R8");
        rd(8'h1A, 8'h0A, "R8");
        issue(3'd4, 8'h1A, 3'd1, 8'h00, 4'h2, K_NONE, 8'h00, "R8");
        rd(8'h1A, 8'h0A, "R8");
        wr(8'h1A, 8'hFF, "R6");
        rd(8'h1A, 8'h00, "R6");

        // R10: unmapped addresses and the no-op code
        wr(8'h10, 8'hAB, "R10");
        rd(8'h10, 8'h00, "R10");
        st(8'h00, 8'hAB, "R10");
        ld(8'h00, 8'h00, "R10");
        ld(8'h90, 8'h00, "R10");
        issue(3'd7, 8'h1C, 3'd0, 8'h00, 4'h0, K_NONE, 8'h00, "R10");
        rd(8'h1C, 8'hE4, "R10");
        bs(8'h05, 3'd0, "R10");
        bt(8'h05, 3'd0, 1'b0, "R10");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule